// File: doc/BRIEF.md
# Polled Safe-Write Sequencer

This block sits on the host side of an SMBus/PMBus link and guards every command write to a power-management target. A requester hands it one write request, either a single data byte or a two-byte word. The block does not issue that write at once. It first reads one byte from the target's manufacturer status command and checks that three readiness flags are all high. Bit 6 means the chip is not busy. Bit 5 means no calculation is pending. Bit 4 means the output is not moving to a new level. The block repeats the status read until all three flags are set, and then issues the write on the very next engine slot. The target therefore never sees a write while it is occupied, and the host needs neither busy-fault handling nor clock stretching at standard bus rates.

The block drives a plain start/done transaction port of an underlying bit-level bus master. A status read that the engine reports as NACKed or errored counts as not ready and is read again. A programmable budget caps the number of status reads, and when it runs out the block returns a timeout. A NACK or error on the write itself is passed back to the requester as a write error and is never retried. One request is handled at a time. `busy` covers the whole exchange, and exactly one of three result pulses marks its end.

Top module: `safe_write_seq`

## Requirements
- R1: After reset, `busy`, `eng_start`, `done`, `nack_err` and `timeout` are all 0.
- R2: A request accepted in idle sets `busy` on the next cycle. The first engine operation is a read-byte (`eng_op` = 0) of the status command `STATUS_CMD` (default 0xEF), and every status read uses that command code.
- R3: A status read counts as ready only when bits 6, 5 and 4 of `eng_rdata` are all 1. The other bits are ignored.
- R4: A status read that completes with `eng_nack` or `eng_err` high counts as not ready, whatever its data (0xFF included). It is followed by another status read.
- R5: A write is started only after a ready status read. Its `eng_start` is seen in the cycle right after that read's `eng_done`. A retried status read likewise starts in the cycle after the previous `eng_done`.
- R6: A byte request issues `eng_op` = 1 with `eng_wdata[7:0]` = data byte and `eng_wdata[15:8]` = 0. A word request issues `eng_op` = 2 with `eng_wdata[7:0]` = low byte (sent first) and `eng_wdata[15:8]` = high byte. `eng_cmd` carries the requested command code in both cases.
- R7: A write that completes with `eng_nack` or `eng_err` gives one `nack_err` pulse and no further engine operation. A clean write gives one `done` pulse.
- R8: `poll_limit` is sampled when a request is accepted, and a value of 0 acts as 1. When that many status reads have come back not ready, the block pulses `timeout` and issues no write.
- R9: `busy` stays high until the result. Exactly one of `done`, `nack_err` and `timeout` is high for one cycle, in the first cycle with `busy` low.
- R10: `req_valid` while `busy` is high is ignored. The transaction in flight keeps its own command, data and poll count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request, taken when idle |
| req_word | input | 1 | 1 = word write, 0 = byte write |
| req_cmd | input | BYTE_W | Command code of the write |
| req_data | input | 2*BYTE_W | Write data, low byte in [7:0] |
| poll_limit | input | POLL_W | Maximum number of status reads (0 acts as 1) |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse: write completed cleanly |
| nack_err | output | 1 | One-cycle pulse: write NACKed or errored |
| timeout | output | 1 | One-cycle pulse: poll budget exhausted |
| eng_start | output | 1 | One-cycle start of an engine transaction |
| eng_op | output | 2 | 0 read-byte, 1 write-byte, 2 write-word |
| eng_cmd | output | BYTE_W | Command code for the engine |
| eng_wdata | output | 2*BYTE_W | Write data for the engine, [7:0] sent first |
| eng_done | input | 1 | Engine transaction complete (one cycle) |
| eng_nack | input | 1 | Engine saw a NACK, valid with eng_done |
| eng_err | input | 1 | Engine error, valid with eng_done |
| eng_rdata | input | BYTE_W | Read byte, valid with eng_done |

## Verification
The bench targets the readiness decode with status bytes that set only the three flags, and with bytes that set every bit except those three. A decoder that looked at the wrong bits, or wanted the whole byte high, would write too early or time out. It also feeds NACKed and errored polls that return 0xFF, which a design that trusted the data alone would take as ready. The budget is tested at limit 0, where a missing clamp would poll forever, and with the ready answer landing on the last allowed read, where an off-by-one would time out. A stray request during a transaction must not change the write's command, and a NACKed write must not be reissued. Byte writes must show a zeroed upper data byte.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [1:0] {
        OP_RD_BYTE = 2'd0,
        OP_WR_BYTE = 2'd1,
        OP_WR_WORD = 2'd2
    } eng_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_GO,
        ST_POLL_WAIT,
        ST_WR_GO,
        ST_WR_WAIT
    } seq_state_e;

endpackage

// File: rtl/sws_ready_check.sv
module sws_ready_check #(
    parameter int               BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] READY_MASK = 8'h70
) (
    input  logic [BYTE_W-1:0] rdata,
    input  logic              nack,
    input  logic              err,
    output logic              ready
);
    logic [BYTE_W-1:0] bit_ok;

    for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
        if (READY_MASK[b]) begin : g_need
            assign bit_ok[b] = rdata[b];
        end else begin : g_skip
            assign bit_ok[b] = 1'b1;
        end
    end

    // R3 / R4: all flagged bits high and a clean completion
    assign ready = (&bit_ok) & ~nack & ~err;
endmodule

// File: rtl/sws_poll_budget.sv
module sws_poll_budget #(
    parameter int POLL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bump,
    input  logic [POLL_W-1:0] limit,
    output logic              last
);
    typedef struct packed {
        logic [POLL_W-1:0] cnt;
        logic [POLL_W-1:0] lim;
    } bud_t;

    bud_t bud_d, bud_q;
    logic [POLL_W:0] cnt_next;

    always_comb begin
        bud_d = bud_q;
        if (load) begin
            bud_d.cnt = '0;
            bud_d.lim = (limit == '0) ? POLL_W'(1) : limit;
        end else if (bump) begin
            bud_d.cnt = bud_q.cnt + POLL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bud_q.cnt <= '0;
            bud_q.lim <= POLL_W'(1);
        end else begin
            bud_q <= bud_d;
        end
    end

    assign cnt_next = {1'b0, bud_q.cnt} + {{POLL_W{1'b0}}, 1'b1};
    assign last     = cnt_next >= {1'b0, bud_q.lim};

    // R8: failed polls never reach the latched budget
    assert_budget_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bud_q.cnt < bud_q.lim);

    // R8: the budget never runs below one
    assert_budget_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bud_q.lim != '0);
endmodule

// File: rtl/safe_write_seq.sv
module safe_write_seq
    import sws_pkg::*;
#(
    parameter int                BYTE_W     = 8,
    parameter int                POLL_W     = 16,
    parameter logic [BYTE_W-1:0] STATUS_CMD = 8'hEF,
    parameter logic [BYTE_W-1:0] READY_MASK = 8'h70,
    localparam int               WORD_W     = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_word,
    input  logic [BYTE_W-1:0] req_cmd,
    input  logic [WORD_W-1:0] req_data,
    input  logic [POLL_W-1:0] poll_limit,
    output logic              busy,
    output logic              done,
    output logic              nack_err,
    output logic              timeout,
    output logic              eng_start,
    output logic [1:0]        eng_op,
    output logic [BYTE_W-1:0] eng_cmd,
    output logic [WORD_W-1:0] eng_wdata,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic              eng_err,
    input  logic [BYTE_W-1:0] eng_rdata
);
    typedef struct packed {
        seq_state_e        st;
        logic              word;
        logic [BYTE_W-1:0] cmd;
        logic [WORD_W-1:0] data;
        logic              done;
        logic              nack;
        logic              tmo;
    } seq_t;

    seq_t seq_d, seq_q;
    logic poll_ready;
    logic bud_load, bud_bump, bud_last;

    sws_ready_check #(
        .BYTE_W     (BYTE_W),
        .READY_MASK (READY_MASK)
    ) ready_i (
        .rdata (eng_rdata),
        .nack  (eng_nack),
        .err   (eng_err),
        .ready (poll_ready)
    );

    sws_poll_budget #(
        .POLL_W (POLL_W)
    ) budget_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (bud_load),
        .bump  (bud_bump),
        .limit (poll_limit),
        .last  (bud_last)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.nack = 1'b0;
        seq_d.tmo  = 1'b0;
        bud_load   = 1'b0;
        bud_bump   = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st   = ST_POLL_GO;
                    seq_d.word = req_word;
                    seq_d.cmd  = req_cmd;
                    seq_d.data = req_data;
                    bud_load   = 1'b1;
                end
            end
            ST_POLL_GO: seq_d.st = ST_POLL_WAIT;
            ST_POLL_WAIT: begin
                if (eng_done) begin
                    if (poll_ready) begin
                        seq_d.st = ST_WR_GO;
                    end else if (bud_last) begin
                        seq_d.st  = ST_IDLE;
                        seq_d.tmo = 1'b1;
                    end else begin
                        seq_d.st = ST_POLL_GO;
                        bud_bump = 1'b1;
                    end
                end
            end
            ST_WR_GO: seq_d.st = ST_WR_WAIT;
            ST_WR_WAIT: begin
                if (eng_done) begin
                    seq_d.st = ST_IDLE;
                    if (eng_nack || eng_err) seq_d.nack = 1'b1;
                    else                     seq_d.done = 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = (seq_q.st != ST_IDLE);
    assign done      = seq_q.done;
    assign nack_err  = seq_q.nack;
    assign timeout   = seq_q.tmo;
    assign eng_start = (seq_q.st == ST_POLL_GO) || (seq_q.st == ST_WR_GO);
    assign eng_op    = (seq_q.st == ST_POLL_GO) ? OP_RD_BYTE :
                       (seq_q.word ? OP_WR_WORD : OP_WR_BYTE);
    assign eng_cmd   = (seq_q.st == ST_POLL_GO) ? STATUS_CMD : seq_q.cmd;
    assign eng_wdata = (seq_q.st == ST_POLL_GO) ? '0 :
                       (seq_q.word ? seq_q.data
                                   : {{BYTE_W{1'b0}}, seq_q.data[BYTE_W-1:0]});

    // Observer of the engine port: remembers whether the latest status read was ready
    logic [1:0] obs_op_q;
    logic       obs_ready_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            obs_op_q    <= OP_RD_BYTE;
            obs_ready_q <= 1'b0;
        end else if (eng_start) begin
            obs_op_q <= eng_op;
            if (eng_op == OP_RD_BYTE) obs_ready_q <= 1'b0;
        end else if (eng_done && obs_op_q == OP_RD_BYTE) begin
            obs_ready_q <= !eng_nack && !eng_err &&
                           ((eng_rdata & READY_MASK) == READY_MASK);
        end
    end

    // R5: a write start follows a ready status read
    assert_write_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && eng_op != OP_RD_BYTE) |-> obs_ready_q);

    // R2: the first engine operation after acceptance is a status read
    assert_first_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (eng_start && eng_op == OP_RD_BYTE));

    // R9: at most one result at a time
    assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, nack_err, timeout}));

    // R9: busy ends only together with a result
    assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || nack_err || timeout));

    // R9: a result is never shown while busy
    assert_result_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || nack_err || timeout) |-> !busy);

    // R7: a start is one cycle wide, so a write is never repeated back to back
    assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);
endmodule

// File: tb/safe_write_seq_tb_top.sv
module safe_write_seq_tb_top;
    localparam int          BW   = 8;
    localparam int          WW   = 16;
    localparam int          PW   = 8;
    localparam logic [7:0]  STAT = 8'hEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_word = 1'b0;
    logic [BW-1:0] req_cmd = '0;
    logic [WW-1:0] req_data = '0;
    logic [PW-1:0] poll_limit = '0;
    logic busy, done, nack_err, timeout, eng_start;
    logic [1:0] eng_op;
    logic [BW-1:0] eng_cmd;
    logic [WW-1:0] eng_wdata;
    logic eng_done = 1'b0, eng_nack = 1'b0, eng_err = 1'b0;
    logic [BW-1:0] eng_rdata = '0;

    always #10 clk = ~clk;

    safe_write_seq #(.BYTE_W(BW), .POLL_W(PW), .STATUS_CMD(STAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_cmd(req_cmd), .req_data(req_data), .poll_limit(poll_limit),
        .busy(busy), .done(done), .nack_err(nack_err), .timeout(timeout),
        .eng_start(eng_start), .eng_op(eng_op), .eng_cmd(eng_cmd),
        .eng_wdata(eng_wdata), .eng_done(eng_done), .eng_nack(eng_nack),
        .eng_err(eng_err), .eng_rdata(eng_rdata));

    int nchk = 0, nerr = 0;
    bit summed = 0;

    // engine model script: 1 partial flags, 2 NACK, 3 error, 5 all bits but flags
    int script [0:63];
    int script_len, poll_idx, wr_resp, lat_max;
    int n_reads, n_writes, bad_cmd, gap_bad, cyc, last_evt;
    logic [1:0] w_op;
    logic [7:0] w_cmd;
    logic [15:0] w_data;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summed) begin
            summed = 1;
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        end
    endtask

    // engine model
    initial begin
        bit pend = 0;
        int cnt = 0;
        logic [1:0] cur_op = 2'd0;
        cyc = 0; last_evt = -10;
        forever begin
            @(negedge clk);
            cyc++;
            eng_done = 0; eng_nack = 0; eng_err = 0;
            if (req_valid === 1'b1 && busy === 1'b0) last_evt = cyc;
            if (pend) begin
                if (cnt == 0) begin
                    pend = 0;
                    last_evt = cyc;
                    eng_done = 1;
                    if (cur_op == 2'd0) begin
                        int kind;
                        logic [7:0] r;
                        kind = (poll_idx < script_len) ? script[poll_idx] : 0;
                        poll_idx++;
                        r = 8'($urandom);
                        case (kind)
                            1: begin r[4 + $urandom_range(0, 2)] = 1'b0; eng_rdata = r; end
                            2: begin eng_nack = 1; eng_rdata = 8'hFF; end
                            3: begin eng_err = 1; eng_rdata = 8'hFF; end
                            4: eng_rdata = 8'h70;
                            5: eng_rdata = 8'h8F;
                            default: eng_rdata = r | 8'h70;
                        endcase
                    end else begin
                        eng_rdata = 8'h00;
                        eng_nack = (wr_resp == 1);
                        eng_err  = (wr_resp == 2);
                    end
                end else cnt--;
            end else if (eng_start === 1'b1) begin
                if (cyc != last_evt + 1) gap_bad++;
                cur_op = eng_op;
                if (eng_op == 2'd0) begin
                    n_reads++;
                    if (eng_cmd != STAT) bad_cmd++;
                end else begin
                    n_writes++;
                    w_op = eng_op; w_cmd = eng_cmd; w_data = eng_wdata;
                end
                pend = 1;
                cnt = $urandom_range(0, lat_max);
            end
        end
    end

    function automatic void expect_of(input int k, input int lim, input int wresp,
                                      output int e_reads, output int e_wr, output int e_res);
        int eff;
        eff = (lim == 0) ? 1 : lim;
        if (k >= eff) begin e_reads = eff; e_wr = 0; e_res = 3; end
        else begin e_reads = k + 1; e_wr = 1; e_res = (wresp == 0) ? 1 : 2; end
    endfunction

    // one transaction; script entries already set, k = not-ready polls before ready
    task automatic run_txn(input int k, input int lim, input bit word, input logic [7:0] cmd,
                           input logic [15:0] data, input int wresp, input bit stray);
        int e_reads, e_wr, e_res, res, waited;
        logic [15:0] e_data;
        script_len = k; poll_idx = 0; wr_resp = wresp;
        n_reads = 0; n_writes = 0; bad_cmd = 0; gap_bad = 0;
        w_op = 0; w_cmd = 0; w_data = 0;
        expect_of(k, lim, wresp, e_reads, e_wr, e_res);
        @(posedge clk); #1;
        req_valid = 1; req_word = word; req_cmd = cmd; req_data = data;
        poll_limit = PW'(lim);
        @(posedge clk); #1;
        req_valid = 0;
        chk(busy === 1'b1, "R2 busy after accept", busy, 1);
        if (stray) begin
            @(posedge clk); #1;
            if (busy === 1'b1) begin
                req_valid = 1; req_cmd = ~cmd; req_data = ~data; req_word = ~word;
                poll_limit = 0;
                @(posedge clk); #1;
                req_valid = 0;
            end
        end
        res = 0; waited = 0;
        while (res == 0 && waited < 3000) begin
            @(negedge clk); #1;
            waited++;
            if (done) res = 1; else if (nack_err) res = 2; else if (timeout) res = 3;
        end
        chk(res == e_res, "R7/R8 result kind", res, e_res);
        chk(busy === 1'b0, "R9 busy low with result", busy, 0);
        chk(n_reads == e_reads, "R4/R8 status read count", n_reads, e_reads);
        chk(bad_cmd == 0, "R2 status command code", bad_cmd, 0);
        chk(n_writes == e_wr, "R5/R7 write count", n_writes, e_wr);
        chk(gap_bad == 0, "R5 start follows completion", gap_bad, 0);
        if (e_wr == 1) begin
            e_data = word ? data : {8'h00, data[7:0]};
            chk(w_op == (word ? 2'd2 : 2'd1), "R6 write op", w_op, word ? 2 : 1);
            chk(w_cmd == cmd, "R6/R10 write command", w_cmd, cmd);
            chk(w_data == e_data, "R6/R10 write data", w_data, e_data);
        end
        @(negedge clk); #1;
        chk({done, nack_err, timeout} == 3'b000, "R9 one-cycle result",
            {done, nack_err, timeout}, 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        lat_max = 3;
        repeat (3) @(negedge clk);
        chk({busy, eng_start, done, nack_err, timeout} == 5'b0, "R1 reset state",
            {busy, eng_start, done, nack_err, timeout}, 0);
        @(posedge clk); #1 rst_n = 1;
        @(negedge clk);
        chk({busy, eng_start, done, nack_err, timeout} == 5'b0, "R1 after release",
            {busy, eng_start, done, nack_err, timeout}, 0);

        // R2/R6: ready at first poll, byte then word
        run_txn(0, 4, 0, 8'h21, 16'hA55A, 0, 0);
        run_txn(0, 4, 1, 8'h21, 16'hBEEF, 0, 0);
        // R3: flags only is ready; all other bits without flags is not
        script[0] = 5; script[1] = 5; script[2] = 4; script_len = 3;
        begin
            script[0] = 5; script[1] = 5;
            run_txn(2, 5, 1, 8'h33, 16'h1234, 0, 0);
        end
        script[0] = 1; script[1] = 1; script[2] = 1;
        run_txn(3, 6, 0, 8'h02, 16'h00C3, 0, 0);
        // R4: NACK and error polls with 0xFF are retried
        script[0] = 2; script[1] = 3; script[2] = 2;
        run_txn(3, 8, 1, 8'h40, 16'h8001, 0, 0);
        // R7: write NACK and write error, no retry
        run_txn(0, 2, 0, 8'hFE, 16'h0077, 1, 0);
        run_txn(0, 2, 1, 8'hFD, 16'h7766, 2, 0);
        // R8: timeout, limit 0 acts as 1, ready on the last allowed poll
        script[0] = 1; script[1] = 2; script[2] = 3; script[3] = 5;
        run_txn(4, 3, 0, 8'h10, 16'h0011, 0, 0);
        script[0] = 2;
        run_txn(1, 0, 0, 8'h11, 16'h0022, 0, 0);
        run_txn(0, 0, 1, 8'h12, 16'h3344, 0, 0);
        script[0] = 1; script[1] = 1; script[2] = 1;
        run_txn(3, 4, 1, 8'h13, 16'h5566, 0, 0);
        // R10: stray request during a transaction
        lat_max = 0;
        script[0] = 1; script[1] = 2; script[2] = 3; script[3] = 1;
        run_txn(4, 9, 1, 8'h5C, 16'hC0DE, 0, 1);
        lat_max = 3;

        // random mix
        for (int t = 0; t < 60; t++) begin
            int k, lim, wr;
            k   = $urandom_range(0, 6);
            lim = $urandom_range(0, 7);
            wr  = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2) : 0;
            for (int i = 0; i < k; i++) script[i] = $urandom_range(1, 3);
            run_txn(k, lim, 1'($urandom), 8'($urandom), 16'($urandom), wr, 0);
        end

        summary();
        $finish;
    end

    initial begin
        #(20 * 150000);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual 1 expected 0");
        summary();
        $finish;
    end
endmodule